// File: doc/BRIEF.md
# Synchronized timer prescaler controller

This block supplies the count enables for a group of timer/counters that share one clock divider. Two free-running divider chains run from the system clock: one serves the timers of the synchronous group, the other the timer(s) of the asynchronous group. Each timer has a 3-bit clock-select field. The field picks one of three kinds of source: stopped, the undivided clock or a divided tap, or an edge of an external clock pin. The block turns that choice into a one-cycle count-enable pulse for the timer. The external pin passes through a two-stage synchronizer and an edge detector. It never goes through a divider chain.

A small control register gives software a reset bit for each divider chain and a lock bit. When the lock bit is clear, writing a one to a reset bit restarts that divider from zero for one cycle, and the bit then clears itself. When the lock bit is set, a one written to a reset bit stays set. That chain is then held at zero with all of its taps silent, so the timers can be loaded with identical values. Clearing the lock bit drops both reset bits at the same time. Every dependent timer then resumes on the same cycle.

Top module: `tmr_presc`

## Requirements
- R1: After reset the register reads 0x00. With every select at 0, no enable pulses.
- R2: The register layout is: bit 7 = lock (read/write), bit 1 = asynchronous-group divider reset, bit 0 = synchronous-group divider reset. Bits 6:2 always read zero. A write of 0x7C reads back 0x00.
- R3: While the lock bit is 1, a reset bit written to one stays one. A later write with that bit at zero does not clear it. While the bit is one, a timer of that group with a divided or undivided select gets no pulses.
- R4: A write that clears the lock bit clears both reset bits in the same cycle. All timers of both groups see their divider restart at zero on that cycle. They pulse together, on the first cycle for select 1 and on the 8th cycle for select 2.
- R5: When the lock bit is 0, a reset bit written to one reads as one for one cycle and then reads zero. Its divider restarts at zero.
- R6: Bit 1 affects only timers in the asynchronous group. Bit 0 affects only timers in the synchronous group.
- R7: Select encoding:
  - 0 = stopped
  - 1 = every cycle
  - 2 = every 8 cycles
  - 3 = every 64 cycles
  - 4 = every 256 cycles
  - 5 = every 1024 cycles
  - 6 = external falling edge
  - 7 = external rising edge

  A divided tap pulses in the last cycle before its low counter bits roll over to zero.
- R8: Each matching pin transition produces exactly one one-cycle pulse, in the cycle after the second clock edge that follows the transition. A transition in the other direction produces no pulse.
- R9: The external edge pulses do not depend on either divider reset. They still appear while the lock bit holds a reset asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read value |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| clk_sel_i | input | 3*NUM_TMR | Per-timer clock select, timer i at bits 3i+2:3i |
| cnt_en_o | output | NUM_TMR | Per-timer one-cycle count enable |

## Verification
A register write takes effect at the clock edge that samples it. The read value and the reset hold are therefore visible one cycle after the write. After a one-cycle self-clearing reset the divider is zero in the second cycle, which puts the first divide-by-N pulse at cycle N+1 after the write. Releasing the lock puts the undivided pulse at cycle 1 and the divide-by-8 pulse at cycle 8. External edges are due exactly two cycles after the pin changes, with no pulse one cycle before or one cycle after. The bench drives inputs and samples outputs only at falling clock edges. It counts those edges from each write or pin change and compares with these fixed offsets.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;
  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  localparam int REG_W         = 8;
  localparam int LOCK_BIT      = 7;
  localparam int RST_ASYNC_BIT = 1;
  localparam int RST_SYNC_BIT  = 0;
  localparam int NUM_TAPS      = 5;
  localparam int SEL_W         = 3;

  // log2 of division ratio for tap idx
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      2:       return 6;
      3:       return 8;
      default: return 10;
    endcase
  endfunction

  localparam int CNT_W = tap_shift(NUM_TAPS - 1);
endpackage

// File: rtl/tmr_presc_ctrl.sv
module tmr_presc_ctrl
  import tmr_presc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             rst_sync_o,
  output logic             rst_async_o
);
  logic       lock_q;
  logic [1:0] rst_q;
  logic [1:0] wr_rst;
  logic       unused_wdata;

  assign wr_rst       = {wdata_i[RST_ASYNC_BIT], wdata_i[RST_SYNC_BIT]};
  assign unused_wdata = ^wdata_i[LOCK_BIT-1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      rst_q  <= 2'b00;
    end else if (we_i) begin
      lock_q <= wdata_i[LOCK_BIT];
      if (wdata_i[LOCK_BIT])      rst_q <= (lock_q ? rst_q : 2'b00) | wr_rst;
      else if (lock_q)            rst_q <= 2'b00;  // release: drop both together
      else                        rst_q <= wr_rst;
    end else if (!lock_q) begin
      rst_q <= 2'b00;  // self-clear pulse
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[LOCK_BIT]      = lock_q;
    rdata_o[RST_ASYNC_BIT] = rst_q[1];
    rdata_o[RST_SYNC_BIT]  = rst_q[0];
  end

  assign rst_sync_o  = rst_q[0];
  assign rst_async_o = rst_q[1];

  a_r3_rst_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && $past(lock_q)) |-> ((rst_q & $past(rst_q)) == $past(rst_q)));

  a_r4_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> (rst_q == 2'b00));

  a_r5_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && rst_q != 2'b00 && !we_i) |=> (rst_q == 2'b00));
endmodule

// File: rtl/tmr_presc_div.sv
module tmr_presc_div
  import tmr_presc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  for (genvar j = 0; j < NUM_TAPS; j++) begin : g_tap
    if (j == 0) begin : g_full
      assign tap_o[j] = !clr_i;
    end else begin : g_div
      assign tap_o[j] = !clr_i && (&cnt_q[tap_shift(j)-1:0]);
    end
  end

  a_r5_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_presc_ext.sv
module tmr_presc_ext (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= 3'b000;
    else         smp_q <= {smp_q[1:0], pin_i};
  end

  // compare synchronized stage against one older sample
  assign rise_o = smp_q[1] & ~smp_q[2];
  assign fall_o = ~smp_q[1] & smp_q[2];

  a_r8_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  a_r8_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_presc_sel.sv
module tmr_presc_sel
  import tmr_presc_pkg::*;
(
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                en_o
);
  clk_sel_e sel;
  assign sel = clk_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      CS_STOP:     en_o = 1'b0;
      CS_DIV1:     en_o = tap_i[0];
      CS_DIV8:     en_o = tap_i[1];
      CS_DIV64:    en_o = tap_i[2];
      CS_DIV256:   en_o = tap_i[3];
      CS_DIV1024:  en_o = tap_i[4];
      CS_EXT_FALL: en_o = fall_i;
      CS_EXT_RISE: en_o = rise_i;
      default:     en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc
  import tmr_presc_pkg::*;
#(
  parameter int                 NUM_TMR    = 3,
  parameter logic [NUM_TMR-1:0] ASYNC_MASK = {1'b1, {(NUM_TMR-1){1'b0}}}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [REG_W-1:0]         reg_wdata_i,
  output logic [REG_W-1:0]         reg_rdata_o,
  input  logic                     ext_clk_i,
  input  logic [SEL_W*NUM_TMR-1:0] clk_sel_i,
  output logic [NUM_TMR-1:0]       cnt_en_o
);
  logic                rst_sync, rst_async;
  logic [NUM_TAPS-1:0] tap_sync, tap_async;
  logic                ext_rise, ext_fall;

  tmr_presc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .rst_sync_o  (rst_sync),
    .rst_async_o (rst_async)
  );

  tmr_presc_div u_div_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rst_sync),
    .tap_o  (tap_sync)
  );

  tmr_presc_div u_div_async (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rst_async),
    .tap_o  (tap_async)
  );

  tmr_presc_ext u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_clk_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [NUM_TAPS-1:0] taps;
    assign taps = ASYNC_MASK[i] ? tap_async : tap_sync;

    tmr_presc_sel u_sel (
      .sel_i  (clk_sel_i[SEL_W*i +: SEL_W]),
      .tap_i  (taps),
      .rise_i (ext_rise),
      .fall_i (ext_fall),
      .en_o   (cnt_en_o[i])
    );
  end

  a_r3_locked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[LOCK_BIT] && reg_rdata_o[RST_SYNC_BIT]) |-> (tap_sync == '0));
endmodule

// File: tb/tmr_presc_bench.sv
module tmr_presc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    wd = 8'h00;
  logic [7:0]    rd;
  logic          ext = 1'b0;
  logic [3*NT-1:0] sel = '0;
  logic [NT-1:0] en;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_presc #(.NUM_TMR(NT), .ASYNC_MASK(3'b100)) u_tmr_presc (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .ext_clk_i(ext), .clk_sel_i(sel), .cnt_en_o(en)
  );

  function automatic int div_of(input int s);
    case (s)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      default: return 1024;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // returns at the first sample after the write edge (k=1)
  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic set_sel(input int t, input int s);
    sel[3*t +: 3] = 3'(s);
  endtask

  // cycles from k=1 until timer t pulses
  task automatic first_pulse(input int t, input int lim, output int k);
    k = 1;
    while (!en[t] && k < lim) begin tick(); k++; end
  endtask

  task automatic count_pulses(input int t, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin tick(); if (en[t]) c++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k, c, s, exp_c, lvl, hp;
    void'($urandom(32'h5eed_0042));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset rdata", rd, 0);
    chk("R1 reset enables", en, 0);

    count_pulses(0, 64, c);
    chk("R7 stop select silent", c, 0);

    set_sel(0, 1);
    count_pulses(0, 32, c);
    chk("R7 undivided every cycle", c, 32);

    // R5 R7: each divider after a self-clearing sync reset
    for (int sv = 1; sv <= 5; sv++) begin
      set_sel(0, sv);
      wr(8'h01);
      chk("R5 reset bit visible", rd, 8'h01);
      first_pulse(0, 2000, k);
      chk("R7 first pulse offset", k, div_of(sv) + 1);
      count_pulses(0, 2 * div_of(sv), c);
      chk("R7 period", c, 2);
    end
    tick();
    chk("R5 reset bit self-cleared", rd, 0);

    // R6 group independence
    for (int t = 0; t < NT; t++) set_sel(t, 1);
    wr(8'h02);
    chk("R6 async reset only async group", en, 3'b011);
    wr(8'h01);
    chk("R6 sync reset only sync group", en, 3'b100);

    // R2 reserved bits
    wr(8'h7C);
    tick();
    chk("R2 reserved read zero", rd, 0);

    // R3 lock
    wr(8'hFF);
    chk("R2 R3 lock readback", rd, 8'h83);
    count_pulses(0, 40, c);
    chk("R3 sync timer held", c, 0);
    count_pulses(2, 40, c);
    chk("R3 async timer held", c, 0);
    wr(8'h80);
    chk("R3 reset bits stay latched", rd, 8'h83);

    // R9 external edges while dividers held
    set_sel(1, 7);
    tick(); ext = 1'b1;
    tick(); chk("R9 no early pulse", en[1], 0);
    tick(); chk("R9 ext pulse under reset", en[1], 1);
    tick(); chk("R9 pulse single", en[1], 0);
    ext = 1'b0;
    repeat (4) tick();

    // R4 simultaneous release
    for (int t = 0; t < NT; t++) set_sel(t, 2);
    wr(8'h00);
    chk("R4 both bits cleared", rd, 0);
    first_pulse(0, 40, k);
    chk("R4 first div8 offset", k, 8);
    chk("R4 all timers together", en, 3'b111);

    // R8 directed
    for (int t = 0; t < NT; t++) set_sel(t, 0);
    set_sel(1, 7);
    tick(); ext = 1'b1;
    tick(); chk("R8 rise k1", en[1], 0);
    tick(); chk("R8 rise k2", en[1], 1);
    tick(); chk("R8 rise k3", en[1], 0);
    ext = 1'b0;
    count_pulses(1, 5, c);
    chk("R8 rise select ignores fall", c, 0);
    set_sel(1, 6);
    ext = 1'b1;
    count_pulses(1, 5, c);
    chk("R8 fall select ignores rise", c, 0);
    ext = 1'b0;
    tick(); chk("R8 fall k1", en[1], 0);
    tick(); chk("R8 fall k2", en[1], 1);
    tick(); chk("R8 fall k3", en[1], 0);

    // R8 random waveforms
    for (int r = 0; r < 8; r++) begin
      s = 6 + int'($urandom % 2);
      set_sel(1, s);
      repeat (4) tick();
      c = 0; exp_c = 0; lvl = 0;
      for (int e = 0; e < 10; e++) begin
        hp = 2 + int'($urandom % 5);
        for (int i = 0; i < hp; i++) begin tick(); if (en[1]) c++; end
        lvl = 1 - lvl;
        ext = lvl[0];
        if ((s == 7 && lvl == 1) || (s == 6 && lvl == 0)) exp_c++;
      end
      for (int i = 0; i < 4; i++) begin tick(); if (en[1]) c++; end
      chk("R8 random edge count", c, exp_c);
    end

    // R6 R7 random dividers on async timer
    set_sel(1, 0);
    for (int r = 0; r < 4; r++) begin
      s = 1 + int'($urandom % 5);
      set_sel(2, s);
      wr(8'h02);
      first_pulse(2, 2000, k);
      chk("R7 R6 async divider offset", k, div_of(s) + 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule